// File: doc/BRIEF.md
# Real-Time Clock Register Port and Interrupt Unit

This block is the processor-facing side of a real-time clock. A host reaches 64 byte locations through an index/data pair on an 8-bit bus. It uses a chip select, one address line, read and write strobes, and a standby input. With the address line low, the host loads or reads a 6-bit location index. With it high, the host reads or writes the location that the index points to.

Two locations are special. The control byte at index 11 holds the interrupt enables and a square-wave enable. The status byte at index 12 holds the event flags and a summary flag. Three event pulses (alarm, end-of-update, periodic) come from the timekeeping logic and set the flags. The summary flag drives an open-drain interrupt request. All other locations are plain byte storage. A hardware reset clears only the enables and the flags, and leaves everything else as it was.

All inputs are sampled on `clk`. The strobes are treated as slow levels and their edges are detected inside the block. The data bus is split into a write-data input, a read-data output and an output-enable. The open-drain request pin is modelled as a pull-down enable.

Top module: `rtc_regport`

## Requirements
- R1: A committed write with `bus_a0`=0 loads the low 6 bits of `bus_wdata` into the index. A read with `bus_a0`=0 returns the index zero-extended to 8 bits.
- R2: With `bus_a0`=1, reads and writes reach the location the index selects. Every index except 11 and 12 is a byte that keeps its last written value.
- R3: A write commits in the first clock cycle in which `bus_wr_n` is sampled high after being sampled low, and only if `bus_cs_n` is low in that cycle. A low pulse with the select high, or a pulse whose rising edge falls after the select is released, changes nothing.
- R4: `bus_rdata_oe` is high only while `bus_cs_n` and `bus_rd_n` are low and `stby_n` and `rst_n` are high. Whenever it is low, `bus_rdata` is 0.
- R5: The control byte (index 11) reads back as written. Bit 6 is the periodic enable, bit 5 the alarm enable, bit 4 the update enable and bit 3 the square-wave enable. Bits 7 and 2..0 are plain storage.
- R6: Each event pulse sets its flag in the status byte (index 12) whether or not it is enabled: bit 6 periodic, bit 5 alarm, bit 4 update. Bits 3..0 read as 0. Writes to the status byte are ignored.
- R7: Status bit 7 is set when some flag is set together with its enable in bit 6, 5 or 4 of the control byte. `irq_pull` follows status bit 7 while `rst_n` and `stby_n` are high. A late enable of a pending flag raises it at once.
- R8: A read of the status byte clears all flags in the cycle where `bus_rd_n` is first sampled high again with the select still low, and this drops `irq_pull`. An event pulse in that same cycle wins, and its flag stays set.
- R9: While `rst_n` is low, the block clears control bits 6..3 and all flags, releases `irq_pull`, keeps `bus_rdata_oe` low and ignores writes. Control bits 7 and 2..0, the index and the storage bytes are kept.
- R10: While `stby_n` is low, `bus_rdata_oe` and `irq_pull` stay low and writes are ignored. Event pulses still set flags, and a pending enabled flag raises `irq_pull` once standby ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low hardware reset (partial clear) |
| bus_cs_n | input | 1 | Active-low block select |
| bus_a0 | input | 1 | 0 = index, 1 = data window |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_wr_n | input | 1 | Active-low write strobe, commits on its rising edge |
| stby_n | input | 1 | Active-low standby, inhibits access |
| bus_wdata | input | 8 | Write data from host |
| bus_rdata | output | 8 | Read data to host |
| bus_rdata_oe | output | 1 | Read-data drive enable (0 = high impedance) |
| evt_alarm | input | 1 | Alarm event pulse |
| evt_update | input | 1 | End-of-update event pulse |
| evt_periodic | input | 1 | Periodic event pulse |
| irq_pull | output | 1 | Open-drain pull-down enable of the active-low interrupt line |

## Verification
The bench aims at the status-read clear.

- An event pulse that lands in the same cycle as the clearing edge must survive. A design that gives the clear priority loses that event silently.
- Writes are tested with the select released before the strobe rises. A design that samples the select at the falling edge would overwrite the index in this case.
- Reset is checked for bits that must survive: the index, a storage byte and the non-enable control bits. A reset that clears the whole control byte would fail here.
- A flag raised during standby must hold the interrupt released until standby ends. A design that gates the flag instead of the pin would lose that interrupt.

// File: rtl/rtc_rp_pkg.sv
package rtc_rp_pkg;

  localparam int DATA_W = 8;
  // event sources, also their order inside the enable and flag fields
  localparam int NSRC = 3;
  localparam int SRC_UPD = 0;
  localparam int SRC_ALM = 1;
  localparam int SRC_PER = 2;
  // lowest bit of the enable field (control byte) and flag field (status byte)
  localparam int FLD_LO = 4;
  localparam int SQW_BIT = 3;
  localparam int SUM_BIT = 7;

  // control bits cleared by hardware reset
  function automatic logic [DATA_W-1:0] reset_clear_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    m[FLD_LO +: NSRC] = '1;
    m[SQW_BIT] = 1'b1;
    return m;
  endfunction

  // summary flag: any pending flag whose enable is set
  function automatic logic irq_summary(logic [NSRC-1:0] flags, logic [DATA_W-1:0] ctrl);
    return |(flags & ctrl[FLD_LO +: NSRC]);
  endfunction

  // status byte layout seen by the host
  function automatic logic [DATA_W-1:0] status_byte(logic [NSRC-1:0] flags, logic sum);
    logic [DATA_W-1:0] s;
    s = '0;
    s[FLD_LO +: NSRC] = flags;
    s[SUM_BIT] = sum;
    return s;
  endfunction

endpackage

// File: rtl/rtc_rp_strobe.sv
module rtc_rp_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic stby_n,
  output logic sel,
  output logic wr_commit,
  output logic rd_done
);

  logic wr_prev;
  logic rd_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_prev <= 1'b1;
      rd_prev <= 1'b1;
    end else begin
      wr_prev <= wr_n;
      rd_prev <= rd_n;
    end
  end

  // access is only possible when selected, out of standby and out of reset
  assign sel       = ~cs_n & stby_n & rst_n;
  assign wr_commit = sel & wr_n & ~wr_prev;
  assign rd_done   = sel & rd_n & ~rd_prev;

endmodule

// File: rtl/rtc_rp_regs.sv
module rtc_rp_regs
  import rtc_rp_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int B_IDX = 11,
  parameter int C_IDX = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_commit,
  input  logic              a0,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] status,
  output logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] ctrl,
  output logic [DATA_W-1:0] rd_mux
);

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] B_SEL = IDX_W'(B_IDX);
  localparam logic [IDX_W-1:0] C_SEL = IDX_W'(C_IDX);
  localparam logic [DATA_W-1:0] RST_MASK = reset_clear_mask();

  logic [DATA_W-1:0] mem [DEPTH];
  logic wr_idx, wr_ctrl, wr_mem;
  logic [DATA_W-1:0] win;

  assign wr_idx  = wr_commit & ~a0;
  assign wr_ctrl = wr_commit & a0 & (idx == B_SEL);
  assign wr_mem  = wr_commit & a0 & (idx != B_SEL) & (idx != C_SEL);

  // index: untouched by reset
  always_ff @(posedge clk) begin
    if (wr_idx) idx <= wdata[IDX_W-1:0];
  end

  // control byte: reset clears only the enable bits
  always_ff @(posedge clk) begin
    if (!rst_n) ctrl <= ctrl & ~RST_MASK;
    else if (wr_ctrl) ctrl <= wdata;
  end

  // general storage
  always_ff @(posedge clk) begin
    if (wr_mem) mem[idx] <= wdata;
  end

  always_comb begin
    if (idx == B_SEL)      win = ctrl;
    else if (idx == C_SEL) win = status;
    else                   win = mem[idx];
  end

  assign rd_mux = a0 ? win : DATA_W'(idx);

endmodule

// File: rtl/rtc_rp_flags.sv
module rtc_rp_flags
  import rtc_rp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt,
  input  logic              clr,
  input  logic [DATA_W-1:0] ctrl,
  output logic [NSRC-1:0]   flags,
  output logic              summary
);

  logic [NSRC-1:0] hits;

  // an event in the clearing cycle wins over the clear
  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else begin
      for (int i = 0; i < NSRC; i++) begin
        if (evt[i])   flags[i] <= 1'b1;
        else if (clr) flags[i] <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_hit
    assign hits[g] = flags[g] & ctrl[FLD_LO + g];
  end

  assign summary = |hits;

endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
  import rtc_rp_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int B_IDX = 11,
  parameter int C_IDX = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs_n,
  input  logic              bus_a0,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  input  logic              stby_n,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rdata_oe,
  input  logic              evt_alarm,
  input  logic              evt_update,
  input  logic              evt_periodic,
  output logic              irq_pull
);

  localparam logic [IDX_W-1:0] C_SEL = IDX_W'(C_IDX);

  logic              sel;
  logic              wr_commit;
  logic              rd_done;
  logic              rd_c_done;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] ctrl;
  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] rd_mux;
  logic [NSRC-1:0]   evt;
  logic [NSRC-1:0]   flags;
  logic              summary;

  assign evt[SRC_UPD] = evt_update;
  assign evt[SRC_ALM] = evt_alarm;
  assign evt[SRC_PER] = evt_periodic;

  rtc_rp_strobe u_strobe (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (bus_cs_n),
    .rd_n      (bus_rd_n),
    .wr_n      (bus_wr_n),
    .stby_n    (stby_n),
    .sel       (sel),
    .wr_commit (wr_commit),
    .rd_done   (rd_done)
  );

  rtc_rp_regs #(
    .IDX_W (IDX_W),
    .B_IDX (B_IDX),
    .C_IDX (C_IDX)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_commit (wr_commit),
    .a0        (bus_a0),
    .wdata     (bus_wdata),
    .status    (status),
    .idx       (idx),
    .ctrl      (ctrl),
    .rd_mux    (rd_mux)
  );

  // the status read is complete when the strobe returns high
  assign rd_c_done = rd_done & bus_a0 & (idx == C_SEL);

  rtc_rp_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt),
    .clr     (rd_c_done),
    .ctrl    (ctrl),
    .flags   (flags),
    .summary (summary)
  );

  assign status       = status_byte(flags, summary);
  assign bus_rdata_oe = sel & ~bus_rd_n;
  assign bus_rdata    = bus_rdata_oe ? rd_mux : '0;
  assign irq_pull     = summary & rst_n & stby_n;

endmodule

// File: rtl/rtc_regport_chk.sv
module rtc_regport_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_cs_n,
  input logic             bus_rd_n,
  input logic             bus_wr_n,
  input logic             stby_n,
  input logic             bus_rdata_oe,
  input logic             irq_pull,
  input logic             evt_alarm,
  input logic             evt_update,
  input logic             evt_periodic,
  input logic             wr_commit,
  input logic             rd_c_done,
  input logic [2:0]       flags,
  input logic [7:0]       ctrl,
  input logic [IDX_W-1:0] idx
);

  AST_OE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_oe |-> (!bus_cs_n && !bus_rd_n && stby_n)); // R4

  AST_WR_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> (!bus_cs_n && bus_wr_n && !$past(bus_wr_n))); // R3

  AST_ALM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_alarm |=> flags[1]); // R6

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pull |-> ((flags[2] && ctrl[6]) || (flags[1] && ctrl[5]) || (flags[0] && ctrl[4]))); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c_done && !evt_alarm && !evt_update && !evt_periodic) |=> (flags == 3'b000)); // R8

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (flags == 3'b000 && ctrl[6:3] == 4'b0000)); // R9

  AST_STBY_NO_IRQ: assert property (@(posedge clk)
    !stby_n |-> !irq_pull); // R10

  AST_STBY_HOLDS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_n |=> $stable(idx)); // R10

endmodule

bind rtc_regport rtc_regport_chk #(.IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_cs_n     (bus_cs_n),
  .bus_rd_n     (bus_rd_n),
  .bus_wr_n     (bus_wr_n),
  .stby_n       (stby_n),
  .bus_rdata_oe (bus_rdata_oe),
  .irq_pull     (irq_pull),
  .evt_alarm    (evt_alarm),
  .evt_update   (evt_update),
  .evt_periodic (evt_periodic),
  .wr_commit    (wr_commit),
  .rd_c_done    (rd_c_done),
  .flags        (flags),
  .ctrl         (ctrl),
  .idx          (idx)
);

// File: tb/rtc_regport_test.sv
module rtc_regport_test;

  localparam int CLK_P = 10;
  localparam int WD_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_cs_n = 1'b1;
  logic bus_a0 = 1'b0;
  logic bus_rd_n = 1'b1;
  logic bus_wr_n = 1'b1;
  logic stby_n = 1'b1;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic bus_rdata_oe;
  logic evt_alarm = 1'b0;
  logic evt_update = 1'b0;
  logic evt_periodic = 1'b0;
  logic irq_pull;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rtc_regport uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_cs_n     (bus_cs_n),
    .bus_a0       (bus_a0),
    .bus_rd_n     (bus_rd_n),
    .bus_wr_n     (bus_wr_n),
    .stby_n       (stby_n),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .bus_rdata_oe (bus_rdata_oe),
    .evt_alarm    (evt_alarm),
    .evt_update   (evt_update),
    .evt_periodic (evt_periodic),
    .irq_pull     (irq_pull)
  );

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(logic a, logic [7:0] d);
    @(negedge clk); bus_cs_n = 1'b0; bus_a0 = a; bus_wdata = d; bus_wr_n = 1'b0;
    @(negedge clk); bus_wr_n = 1'b1;
    @(negedge clk); bus_cs_n = 1'b1;
  endtask

  task automatic bus_rd(logic a, output logic [7:0] v, output logic oe);
    @(negedge clk); bus_cs_n = 1'b0; bus_a0 = a; bus_rd_n = 1'b0;
    #1; v = bus_rdata; oe = bus_rdata_oe;
    @(negedge clk); bus_rd_n = 1'b1;
    @(negedge clk); bus_cs_n = 1'b1;
  endtask

  task automatic set_loc(logic [7:0] i, logic [7:0] d);
    bus_wr(1'b0, i);
    bus_wr(1'b1, d);
  endtask

  task automatic get_loc(logic [7:0] i, output logic [7:0] v);
    logic oe;
    bus_wr(1'b0, i);
    bus_rd(1'b1, v, oe);
  endtask

  task automatic pulse(logic p, logic a, logic u);
    @(negedge clk); evt_periodic = p; evt_alarm = a; evt_update = u;
    @(negedge clk); evt_periodic = 1'b0; evt_alarm = 1'b0; evt_update = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [7:0] v;
    @(negedge clk); bus_cs_n = 1'b0; bus_rd_n = 1'b0; #1;
    chk("R9", "oe during reset", bus_rdata_oe, 0);
    chk("R9", "irq during reset", irq_pull, 0);
    @(negedge clk); bus_cs_n = 1'b1; bus_rd_n = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    get_loc(8'd11, v);
    chk("R9", "ctrl enables after reset", int'(v & 8'h78), 0);
    get_loc(8'd12, v);
    chk("R9", "status after reset", v, 8'h00);
  endtask

  task automatic t_index();
    logic [7:0] v; logic oe;
    bus_wr(1'b0, 8'h2A);
    bus_rd(1'b0, v, oe);
    chk("R1", "index readback", v, 8'h2A);
    chk("R4", "oe during read", oe, 1);
    bus_wr(1'b0, 8'hFF);
    bus_rd(1'b0, v, oe);
    chk("R1", "index width", v, 8'h3F);
  endtask

  task automatic t_storage();
    logic [7:0] v;
    set_loc(8'd0, 8'h11);
    set_loc(8'd13, 8'h5C);
    set_loc(8'd14, 8'hA7);
    set_loc(8'd40, 8'h3E);
    set_loc(8'd63, 8'hC9);
    get_loc(8'd0, v);  chk("R2", "loc 0", v, 8'h11);
    get_loc(8'd13, v); chk("R2", "loc 13", v, 8'h5C);
    get_loc(8'd14, v); chk("R2", "loc 14", v, 8'hA7);
    get_loc(8'd40, v); chk("R2", "loc 40", v, 8'h3E);
    get_loc(8'd63, v); chk("R2", "loc 63", v, 8'hC9);
  endtask

  task automatic t_strobe();
    logic [7:0] v; logic oe;
    bus_wr(1'b0, 8'd17);
    // pulse with select high
    @(negedge clk); bus_a0 = 1'b0; bus_wdata = 8'd9; bus_wr_n = 1'b0;
    @(negedge clk); bus_wr_n = 1'b1;
    @(negedge clk);
    bus_rd(1'b0, v, oe);
    chk("R3", "write without select", v, 8'd17);
    // select released before the rising edge
    @(negedge clk); bus_cs_n = 1'b0; bus_wdata = 8'd9; bus_wr_n = 1'b0;
    @(negedge clk); bus_cs_n = 1'b1;
    @(negedge clk); bus_wr_n = 1'b1;
    @(negedge clk);
    bus_rd(1'b0, v, oe);
    chk("R3", "select gone at rising edge", v, 8'd17);
  endtask

  task automatic t_oe();
    @(negedge clk); bus_cs_n = 1'b1; bus_rd_n = 1'b0; #1;
    chk("R4", "oe without select", bus_rdata_oe, 0);
    chk("R4", "rdata without select", bus_rdata, 0);
    @(negedge clk); bus_rd_n = 1'b1; bus_cs_n = 1'b0; #1;
    chk("R4", "oe without strobe", bus_rdata_oe, 0);
    @(negedge clk); bus_cs_n = 1'b1;
  endtask

  task automatic t_ctrl();
    logic [7:0] v;
    set_loc(8'd11, 8'hFF);
    get_loc(8'd11, v); chk("R5", "ctrl all ones", v, 8'hFF);
    set_loc(8'd11, 8'h00);
    get_loc(8'd11, v); chk("R5", "ctrl zero", v, 8'h00);
  endtask

  task automatic t_flags();
    logic [7:0] v;
    pulse(1'b0, 1'b1, 1'b0);
    #1; chk("R6", "masked alarm no irq", irq_pull, 0);
    get_loc(8'd12, v); chk("R6", "alarm flag", v, 8'h20);
    get_loc(8'd12, v); chk("R8", "cleared after read", v, 8'h00);
    pulse(1'b0, 1'b0, 1'b1);
    set_loc(8'd12, 8'hF0);
    get_loc(8'd12, v); chk("R6", "status write ignored", v, 8'h10);
  endtask

  task automatic t_summary();
    logic [7:0] v;
    set_loc(8'd11, 8'h40);
    pulse(1'b1, 1'b0, 1'b0);
    #1; chk("R7", "periodic irq", irq_pull, 1);
    get_loc(8'd12, v); chk("R7", "status with summary", v, 8'hC0);
    #1; chk("R8", "irq dropped by read", irq_pull, 0);
    set_loc(8'd11, 8'h10);
    pulse(1'b0, 1'b1, 1'b0);
    #1; chk("R7", "alarm masked", irq_pull, 0);
    set_loc(8'd11, 8'h30);
    #1; chk("R7", "late enable raises irq", irq_pull, 1);
    get_loc(8'd12, v); chk("R7", "alarm summary", v, 8'hA0);
  endtask

  task automatic t_clear_race();
    logic [7:0] v;
    set_loc(8'd11, 8'h00);
    pulse(1'b0, 1'b1, 1'b0);
    bus_wr(1'b0, 8'd12);
    @(negedge clk); bus_cs_n = 1'b0; bus_a0 = 1'b1; bus_rd_n = 1'b0;
    #1; v = bus_rdata;
    @(negedge clk); bus_rd_n = 1'b1; evt_update = 1'b1;
    @(negedge clk); evt_update = 1'b0; bus_cs_n = 1'b1;
    chk("R8", "read value before race", v, 8'h20);
    get_loc(8'd12, v); chk("R8", "event wins over clear", v, 8'h10);
  endtask

  task automatic t_hw_reset();
    logic [7:0] v; logic oe;
    set_loc(8'd11, 8'hFF);
    pulse(1'b1, 1'b0, 1'b0);
    #1; chk("R7", "irq before reset", irq_pull, 1);
    set_loc(8'd20, 8'h5A);
    bus_wr(1'b0, 8'd33);
    @(negedge clk); rst_n = 1'b0;
    #1; chk("R9", "irq released in reset", irq_pull, 0);
    bus_wr(1'b0, 8'd5);
    @(negedge clk); bus_cs_n = 1'b0; bus_a0 = 1'b0; bus_rd_n = 1'b0;
    #1; chk("R9", "no drive in reset", bus_rdata_oe, 0);
    @(negedge clk); bus_rd_n = 1'b1; bus_cs_n = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    bus_rd(1'b0, v, oe); chk("R9", "index kept", v, 8'd33);
    get_loc(8'd11, v); chk("R9", "ctrl partial clear", v, 8'h87);
    get_loc(8'd12, v); chk("R9", "flags cleared", v, 8'h00);
    get_loc(8'd20, v); chk("R9", "storage kept", v, 8'h5A);
  endtask

  task automatic t_standby();
    logic [7:0] v; logic oe;
    set_loc(8'd11, 8'h40);
    bus_wr(1'b0, 8'd20);
    @(negedge clk); stby_n = 1'b0;
    bus_wr(1'b0, 8'd7);
    bus_rd(1'b0, v, oe); chk("R10", "no drive in standby", oe, 0);
    pulse(1'b1, 1'b0, 1'b0);
    #1; chk("R10", "irq held in standby", irq_pull, 0);
    @(negedge clk); stby_n = 1'b1;
    #1; chk("R10", "irq after standby", irq_pull, 1);
    bus_rd(1'b0, v, oe); chk("R10", "index unchanged", v, 8'd20);
    get_loc(8'd12, v); chk("R10", "flag set in standby", v, 8'hC0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    t_index();
    t_storage();
    t_strobe();
    t_oe();
    t_ctrl();
    t_flags();
    t_summary();
    t_clear_race();
    t_hw_reset();
    t_standby();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule